// File: doc/BRIEF.md
# Buffered Async Character Receiver

This block turns a demodulated, bit-rate serial line into host-readable characters. A sample tick at sixteen times the bit rate drives a start-bit hunter and a bit-centre sampler. Each character is framed by a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two stop bits. A finished character first lands in a one-entry holding stage. On the next clock it is copied into the receive data register, where the host picks it up.

Four sticky flags go with the data register: data ready, overflow, framing error and parity error. A single host read strobe clears all four. Two line conditions get special handling. A character whose every sampled bit is zero counts as a framing error, and the receiver then waits for the line to return high before it hunts again. A separate detector raises an indication once an unbroken run of zero bits grows longer than twice the character length plus three.

Top module: `async_char_rx`

## Requirements
- R1: A completed character is held one clock in a holding stage and then copied to `rx_data`, which sets `data_ready`. Bits not used by the selected data length read as 0.
- R2: If `data_ready` is still 1 when a new character is copied in, with no host read in that same clock, `overflow` becomes 1.
- R3: A clock with `host_rd` high and no copy in progress clears `data_ready`, `overflow`, `framing_err` and `parity_err` to 0. `rx_data` keeps its value.
- R4: A character whose start, data, parity and stop samples are all 0 sets `framing_err`.
- R5: After an all-zero character the receiver starts no new character while the line stays low. It resumes only after the line goes high and then falls again.
- R6: `zeros_detect` is 1 while the count of consecutive zero bit samples exceeds 2M+3. M is the data bits plus the parity bit (if enabled) plus the stop bits. The start bit is counted as a sample. Any sampled 1 resets the count to 0.
- R7: `cfg_dbits` code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. The first data bit received lands in `rx_data[0]`.
- R8: With `cfg_par_en`=1, `cfg_par_odd`=0 checks even parity and 1 checks odd parity, over the data and parity bits together. A mismatch sets `parity_err`, which stays set until a host read.
- R9: `cfg_two_stop`=1 samples two stop bits. Any stop sample that reads 0 sets `framing_err`.
- R10: A start bit is confirmed at the middle of its bit period, 8 ticks after the falling edge. A low pulse shorter than that starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle enable at 16x bit rate |
| rx_line | input | 1 | Demodulated serial line, idle high |
| cfg_dbits | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| host_rd | input | 1 | Host read strobe of the data register |
| rx_data | output | 8 | Receive data register |
| data_ready | output | 1 | Unread character present |
| overflow | output | 1 | Character replaced before it was read |
| framing_err | output | 1 | Sticky framing error |
| parity_err | output | 1 | Sticky parity error |
| zeros_detect | output | 1 | Long zero run indication |

## Verification
On every clock, the embedded properties check the flag rules:
- a copy always raises data ready;
- a read with no copy clears all flags;
- overflow only rises over an unread character;
- an all-zero character always leads to a framing error;
- a sampled 1 drops the zero-run indication;
- the hold state after an all-zero character never enters the start state directly;
- a start bit that is high at its midpoint falls back to idle.

The scenarios cover what no single-cycle property can show: correct bit order and masking for each data length, parity sense, two-stop framing, glitch rejection, the exact zero-run threshold window, and correct reception of the first clean character after the line recovers.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam int MAX_DBITS = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_t;

  typedef struct packed {
    logic [MAX_DBITS-1:0] data;
    logic                 frm_err;
    logic                 par_err;
  } rx_char_t;

  function automatic int unsigned data_len(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  // bits per character after the start bit: data + parity + stop
  function automatic int unsigned char_len(input logic [1:0] code,
                                           input logic par_en,
                                           input logic two_stop);
    return data_len(code) + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

  function automatic int unsigned zero_limit(input logic [1:0] code,
                                             input logic par_en,
                                             input logic two_stop);
    return 2 * char_len(code, par_en, two_stop) + 3;
  endfunction

endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import acr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic [1:0] cfg_dbits,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     two_stop,
  output logic     bit_valid,
  output logic     bit_val,
  output logic     char_done,
  output logic     all_zero,
  output rx_char_t char_out
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  rx_state_t             state;
  logic [PH_W-1:0]       ph;
  logic [2:0]            idx;
  logic [MAX_DBITS-1:0]  shreg;
  logic                  par_acc, par_bad, stop_bad, any_one;

  logic       at_mid;
  logic [2:0] last_idx;
  logic       stop_bad_n, any_n;

  assign at_mid     = (ph == PH_LAST);
  assign last_idx   = 3'(data_len(cfg_dbits) - 1);
  assign stop_bad_n = stop_bad | ~line;
  assign any_n      = any_one | line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ph        <= '0;
      idx       <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bad   <= 1'b0;
      stop_bad  <= 1'b0;
      any_one   <= 1'b0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
      char_done <= 1'b0;
      all_zero  <= 1'b0;
      char_out  <= '0;
    end else begin
      bit_valid <= 1'b0;
      char_done <= 1'b0;
      if (tick) begin
        unique case (state)
          S_IDLE: begin
            if (!line) begin
              state <= S_START;
              ph    <= '0;
            end
          end
          S_START: begin
            if (ph == PH_HALF) begin
              ph <= '0;
              if (!line) begin
                state     <= S_DATA;
                idx       <= '0;
                shreg     <= '0;
                par_acc   <= par_odd;
                par_bad   <= 1'b0;
                stop_bad  <= 1'b0;
                any_one   <= 1'b0;
                bit_valid <= 1'b1;
                bit_val   <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          S_DATA: begin
            if (at_mid) begin
              ph         <= '0;
              shreg[idx] <= line;
              par_acc    <= par_acc ^ line;
              any_one    <= any_n;
              bit_valid  <= 1'b1;
              bit_val    <= line;
              if (idx == last_idx) begin
                state <= par_en ? S_PAR : S_STOP;
                idx   <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          S_PAR: begin
            if (at_mid) begin
              ph        <= '0;
              par_bad   <= par_acc ^ line;
              any_one   <= any_n;
              bit_valid <= 1'b1;
              bit_val   <= line;
              state     <= S_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          S_STOP: begin
            if (at_mid) begin
              ph        <= '0;
              bit_valid <= 1'b1;
              bit_val   <= line;
              if (two_stop && idx == 3'd0) begin
                idx      <= 3'd1;
                stop_bad <= stop_bad_n;
                any_one  <= any_n;
              end else begin
                char_done        <= 1'b1;
                char_out.data    <= shreg;
                char_out.frm_err <= stop_bad_n;
                char_out.par_err <= par_bad;
                all_zero         <= ~any_n;
                state            <= any_n ? S_IDLE : S_HOLD;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          S_HOLD: begin
            if (line) begin
              state     <= S_IDLE;
              bit_valid <= 1'b1;
              bit_val   <= 1'b1;
            end else if (at_mid) begin
              ph        <= '0;
              bit_valid <= 1'b1;
              bit_val   <= 1'b0;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HOLD |=> (state == S_HOLD || state == S_IDLE)); // R5
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick && ph == PH_HALF && line) |=> state == S_IDLE); // R10

endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
  import acr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_done,
  input  rx_char_t             char_in,
  input  logic                 host_rd,
  output logic                 copy_en,
  output logic [MAX_DBITS-1:0] rx_data,
  output logic                 data_ready,
  output logic                 overflow,
  output logic                 framing_err,
  output logic                 parity_err
);
  rx_char_t hold_q;
  logic     hold_full;

  assign copy_en = hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      hold_full <= char_done;
      if (char_done) hold_q <= char_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      data_ready  <= 1'b0;
      overflow    <= 1'b0;
      framing_err <= 1'b0;
      parity_err  <= 1'b0;
    end else if (hold_full) begin
      rx_data     <= hold_q.data;
      data_ready  <= 1'b1;
      overflow    <= data_ready & ~host_rd;
      framing_err <= (framing_err & ~host_rd) | hold_q.frm_err;
      parity_err  <= (parity_err & ~host_rd) | hold_q.par_err;
    end else if (host_rd) begin
      data_ready  <= 1'b0;
      overflow    <= 1'b0;
      framing_err <= 1'b0;
      parity_err  <= 1'b0;
    end
  end

  AST_COPY_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> data_ready); // R1
  AST_OVF_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(data_ready)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !copy_en) |=> !(data_ready || overflow || framing_err || parity_err)); // R3

endmodule

// File: rtl/rx_zero_run.sv
module rx_zero_run #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] limit,
  output logic             zeros_detect
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (bit_valid) begin
      if (bit_val) run_cnt <= '0;
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign zeros_detect = (run_cnt > limit);

  AST_ONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_val) |=> !zeros_detect); // R6

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import acr_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx_line,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       host_rd,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overflow,
  output logic       framing_err,
  output logic       parity_err,
  output logic       zeros_detect
);
  logic             bit_valid, bit_val, char_done, all_zero, copy_en;
  rx_char_t         char_w;
  logic [CNT_W-1:0] run_limit;

  assign run_limit = CNT_W'(zero_limit(cfg_dbits, cfg_par_en, cfg_two_stop));

  rx_bit_sampler #(.OSR(OSR)) sampler_i (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(rx_line),
    .cfg_dbits(cfg_dbits), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .bit_valid(bit_valid), .bit_val(bit_val),
    .char_done(char_done), .all_zero(all_zero), .char_out(char_w)
  );

  rx_hold_regs regs_i (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_in(char_w),
    .host_rd(host_rd), .copy_en(copy_en), .rx_data(rx_data),
    .data_ready(data_ready), .overflow(overflow),
    .framing_err(framing_err), .parity_err(parity_err)
  );

  rx_zero_run #(.CNT_W(CNT_W)) zrun_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
    .limit(run_limit), .zeros_detect(zeros_detect)
  );

  AST_ALLZERO_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && all_zero) ##1 copy_en |=> framing_err); // R4

endmodule

// File: tb/async_char_rx_tb_top.sv
module async_char_rx_tb_top;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic host_rd = 1'b0;
  logic [1:0] cfg_dbits = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [1:0] div = '0;
  logic sample_tick;
  logic [7:0] rx_data;
  logic data_ready, overflow, framing_err, parity_err, zeros_detect;

  always #10 clk = ~clk;
  always @(negedge clk) div <= div + 1'b1;
  assign sample_tick = (div == 2'd0);

  async_char_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .host_rd(host_rd), .rx_data(rx_data),
    .data_ready(data_ready), .overflow(overflow), .framing_err(framing_err),
    .parity_err(parity_err), .zeros_detect(zeros_detect)
  );

  typedef struct {
    string    req;
    logic [7:0] data;
    logic     fe, pe, ovf;
  } exp_t;

  exp_t sb_q[$];
  event frame_ev;
  int n_chk = 0, n_fail = 0;
  bit m_ready = 0, m_fe = 0, m_pe = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic hold_bits(input int nbits);
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input string req, input logic [7:0] d, input int nb,
                           input bit pen, input bit podd, input bit ts,
                           input bit flip_par, input bit bad_stop2);
    logic [7:0] mask;
    logic p;
    exp_t it;
    cfg_dbits = 2'(nb - 5); cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = ts;
    hold_bits(1);
    mask = 8'((1 << nb) - 1);
    p = ^(d & mask) ^ podd ^ flip_par;
    rx_line = 1'b0; hold_bits(1);
    for (int i = 0; i < nb; i++) begin rx_line = d[i]; hold_bits(1); end
    if (pen) begin rx_line = p; hold_bits(1); end
    rx_line = 1'b1; hold_bits(1);
    if (ts) begin rx_line = ~bad_stop2; hold_bits(1); end
    rx_line = 1'b1; hold_bits(1);
    it.req = req; it.data = d & mask;
    it.fe = m_fe | (ts & bad_stop2);
    it.pe = m_pe | (pen & flip_par);
    it.ovf = m_ready;
    m_ready = 1; m_fe = it.fe; m_pe = it.pe;
    sb_q.push_back(it);
    -> frame_ev;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic host_read(input string req);
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0; @(negedge clk);
    m_ready = 0; m_fe = 0; m_pe = 0;
    check(req, "ready after read", data_ready, 0);
    check(req, "flags after read", {overflow, framing_err, parity_err}, 0);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(frame_ev);
      @(negedge clk);
      it = sb_q.pop_front();
      check(it.req, "rx_data", rx_data, it.data);
      check(it.req, "data_ready", data_ready, 1);
      check(it.req, "framing_err", framing_err, it.fe);
      check(it.req, "parity_err", parity_err, it.pe);
      check(it.req, "overflow", overflow, it.ovf);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset flags", {data_ready, overflow, framing_err, parity_err, zeros_detect}, 0);
    check("R1", "reset data", rx_data, 0);

    send_char("R7", 8'hA5, 8, 0, 0, 0, 0, 0);       // R1 R7 8N1, LSB first
    host_read("R3");
    check("R3", "data kept", rx_data, 8'hA5);
    send_char("R8", 8'hF5, 5, 1, 0, 0, 0, 0);       // R7 5 bits even, masks to 0x15
    host_read("R3");
    send_char("R8", 8'h3C, 7, 1, 1, 1, 1, 0);       // R8 odd parity, flipped
    send_char("R2", 8'h41, 7, 1, 1, 1, 0, 0);       // R2 overflow, R8 sticky parity
    host_read("R3");
    send_char("R9", 8'h2B, 6, 0, 0, 1, 0, 1);       // R9 second stop low
    host_read("R3");

    // R10: short low glitch (4 ticks)
    rx_line = 1'b0; repeat (16) @(negedge clk); rx_line = 1'b1;
    hold_bits(12);
    check("R10", "glitch ready", data_ready, 0);

    // R4 R5 R6: all-zero 8N1 character, line kept low
    cfg_dbits = 2'd3; cfg_par_en = 0; cfg_two_stop = 0;
    hold_bits(1);
    rx_line = 1'b0;
    repeat (10 * BITCLK + BITCLK / 2) @(negedge clk);
    check("R4", "all-zero framing_err", framing_err, 1);
    check("R4", "all-zero ready", data_ready, 1);
    check("R4", "all-zero data", rx_data, 0);
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    repeat (9 * BITCLK + BITCLK / 2 - 1) @(negedge clk);  // at 20 bits
    check("R6", "below 2M+3", zeros_detect, 0);
    hold_bits(3);                                        // at 23 bits
    check("R6", "above 2M+3", zeros_detect, 1);
    hold_bits(17);
    check("R5", "no char while low", data_ready, 0);
    rx_line = 1'b1; hold_bits(1);
    check("R6", "run cleared by 1", zeros_detect, 0);
    send_char("R5", 8'h5A, 8, 0, 0, 0, 0, 0);       // R5 resync after line high

    finish_run();
  end
endmodule